// File: doc/BRIEF.md
# Eight-bit Microcontroller ALU with Word Operations

This block is the arithmetic and logic unit of an 8-bit RISC microcontroller pipeline. It is driven directly by one execute stage, which supplies:

- the values on two register-file read ports;
- an immediate byte taken from the instruction;
- an operand-select bit;
- a word-mode bit;
- an operation code;
- the current status flags.

The block returns a 16-bit result, a result write-enable and an updated six-bit flag vector. The first operand is either one byte from read port 1 or a 16-bit word assembled from both read ports. The second operand is always one byte, taken from read port 2 or from the immediate.

The unit covers byte arithmetic with and without carry, compares, increment, decrement, negate, complement, bitwise logic, three right shifts and a nibble swap. It also covers word add and subtract of a small immediate and byte or word moves. Multiply comes in unsigned, signed and mixed-sign forms, each with a fractional variant.

All of the computation is combinational. Result, flags and write-enable are captured in one output register stage. That stage loads while the stage-enable input is high and clears on a synchronous reset.

Top module: `mcuAlu`

## Requirements
- R1: Operand A is `rdA` when `wordMode` is 0, and `{rdB, rdA}` (rdA low byte) when `wordMode` is 1. Byte operations use only the low byte of operand A. MOVW returns the whole of operand A, and MOV returns `{8'h00, low byte}`.
- R2: Operand B is `immByte` when `useImm` is 1 and `rdB` when it is 0.
- R3: Flag vector bits are C=0, Z=1, N=2, V=3, S=4, H=5. The opcodes are ADD=0, ADC=1 and SUB=3, and every byte result appears as `{8'h00, r}`.
  - ADD and ADC compute A+B(+C). SUB computes A-B.
  - C is the carry (or borrow) out of bit 7, and H is the carry (or borrow) out of bit 3.
  - V is two's-complement overflow, N is bit 7, Z is result==0, and S=N^V.
- R4: SBC=4 computes A-B-C and CMPC=14 compares A with B+C, with the flags of R3. Their Z is set only when the result is zero and the incoming Z is 1.
- R5: CMP=13 and CMPC=14 update the flags as a subtraction would, but drive `resultWe` low.
- R6: ADDW=2 and SUBW=5 add or subtract the zero-extended `immByte[5:0]` to the 16-bit operand A, regardless of `useImm`.
  - C is the carry or borrow out of bit 15, and V is signed 16-bit overflow.
  - N is bit 15, Z is word==0 and S=N^V. H is unchanged.
- R7: INC=6 and DEC=7 leave C and H unchanged, and V is set when the result is 0x80 or 0x7F respectively. COM=11 forces C=1 and V=0. NEG=12 computes 0-A with C = result nonzero, V = result==0x80 and H = low nibble of A nonzero. N, Z and S are as in R3 for all four.
- R8: AND=8, OR=9 and XOR=10 give V=0, N, Z and S=N^V, and leave C and H unchanged.
- R9: The right shifts are LSR=16 (zero in), ROR=17 (incoming C in) and ASR=18 (bit 7 kept).
  - C is the old bit 0.
  - N is the new bit 7, V=N^C and S=N^V.
  - H is unchanged.
- R10: SWAP=15 exchanges the nibbles of the low byte, and MOV=25 and MOVW=26 pass operand A through. All three leave every flag unchanged.
- R11: MULUU=19, MULSS=20 and MULSU=21 give the 16-bit product of A and B, read as unsigned×unsigned, signed×signed and signed×unsigned. C is product bit 15 and Z is product==0, and the other flags are unchanged.
- R12: FMULUU=22, FMULSS=23 and FMULSU=24 return the product of the matching R11 form shifted left by one. C is product bit 15 before the shift and Z is the shifted result==0.
- R13: Outputs change one clock after the inputs, only while `stageEn` is 1, and hold otherwise. A synchronous `rst` clears the result, the flags and `resultWe` on the next edge.
- R14: Any other opcode gives result 0, `resultWe` 0 and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stageEn | input | 1 | Output stage load enable |
| rdA | input | 8 | Register read port 1 |
| rdB | input | 8 | Register read port 2 |
| immByte | input | 8 | Immediate byte from the instruction |
| useImm | input | 1 | Select immediate as operand B |
| wordMode | input | 1 | Build operand A as a 16-bit word |
| opCode | input | 5 | Operation code |
| flagsIn | input | 6 | Incoming status flags |
| result | output | 16 | Registered result |
| flagsOut | output | 6 | Registered updated flags |
| resultWe | output | 1 | Registered result write-enable |

## Verification
A control strobe decoded wrongly, or a mis-selected operand, appears in the result or in the flags on the first edge after the faulty operation is applied. The datapath holds no state between operations, so every error is confined to a single operation and cannot hide. Any error in the one stateful part, the output stage, shows in two ways at the next edge: outputs that move while the stage is disabled, or values that stay non-zero after a reset.

// File: rtl/aluPkg.sv
package aluPkg;
  localparam int DATA_W = 8;
  localparam int WIMM_W = 6;
  localparam int FLAG_W = 6;
  localparam int OP_W   = 5;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_ADDW = 5'd2,  OP_SUB = 5'd3,
    OP_SBC = 5'd4,  OP_SUBW = 5'd5, OP_INC = 5'd6,   OP_DEC = 5'd7,
    OP_AND = 5'd8,  OP_OR = 5'd9,   OP_XOR = 5'd10,  OP_COM = 5'd11,
    OP_NEG = 5'd12, OP_CMP = 5'd13, OP_CMPC = 5'd14, OP_SWAP = 5'd15,
    OP_LSR = 5'd16, OP_ROR = 5'd17, OP_ASR = 5'd18,
    OP_MULUU = 5'd19, OP_MULSS = 5'd20, OP_MULSU = 5'd21,
    OP_FMULUU = 5'd22, OP_FMULSS = 5'd23, OP_FMULSU = 5'd24,
    OP_MOV = 5'd25, OP_MOVW = 5'd26
  } aluOpE;

  typedef enum logic [3:0] {
    CL_NONE, CL_ADD, CL_SUB, CL_ADDW, CL_SUBW, CL_INC, CL_DEC,
    CL_LOGIC, CL_COM, CL_NEG, CL_SWAP, CL_SHIFT, CL_MUL, CL_MOV
  } opClassE;

  typedef struct packed {
    opClassE    opClass;
    logic       useCarry;
    logic       zChain;
    logic [1:0] subSel;
    logic       signA;
    logic       signB;
    logic       fract;
    logic       wordOut;
    logic       writeRes;
  } aluCtrlT;
endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluCtrlT         ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.opClass  = CL_NONE;
    ctrl.writeRes = 1'b1;
    unique case (aluOpE'(opCode))
      OP_ADD:  ctrl.opClass = CL_ADD;
      OP_ADC:  begin ctrl.opClass = CL_ADD; ctrl.useCarry = 1'b1; end
      OP_ADDW: ctrl.opClass = CL_ADDW;
      OP_SUB:  ctrl.opClass = CL_SUB;
      OP_SBC:  begin ctrl.opClass = CL_SUB; ctrl.useCarry = 1'b1; ctrl.zChain = 1'b1; end
      OP_SUBW: ctrl.opClass = CL_SUBW;
      OP_INC:  ctrl.opClass = CL_INC;
      OP_DEC:  ctrl.opClass = CL_DEC;
      OP_AND:  begin ctrl.opClass = CL_LOGIC; ctrl.subSel = 2'd0; end
      OP_OR:   begin ctrl.opClass = CL_LOGIC; ctrl.subSel = 2'd1; end
      OP_XOR:  begin ctrl.opClass = CL_LOGIC; ctrl.subSel = 2'd2; end
      OP_COM:  ctrl.opClass = CL_COM;
      OP_NEG:  ctrl.opClass = CL_NEG;
      OP_CMP:  begin ctrl.opClass = CL_SUB; ctrl.writeRes = 1'b0; end
      OP_CMPC: begin
        ctrl.opClass = CL_SUB; ctrl.useCarry = 1'b1; ctrl.zChain = 1'b1;
        ctrl.writeRes = 1'b0;
      end
      OP_SWAP: ctrl.opClass = CL_SWAP;
      OP_LSR:  begin ctrl.opClass = CL_SHIFT; ctrl.subSel = 2'd0; end
      OP_ROR:  begin ctrl.opClass = CL_SHIFT; ctrl.subSel = 2'd1; end
      OP_ASR:  begin ctrl.opClass = CL_SHIFT; ctrl.subSel = 2'd2; end
      OP_MULUU:  ctrl.opClass = CL_MUL;
      OP_MULSS:  begin ctrl.opClass = CL_MUL; ctrl.signA = 1'b1; ctrl.signB = 1'b1; end
      OP_MULSU:  begin ctrl.opClass = CL_MUL; ctrl.signA = 1'b1; end
      OP_FMULUU: begin ctrl.opClass = CL_MUL; ctrl.fract = 1'b1; end
      OP_FMULSS: begin
        ctrl.opClass = CL_MUL; ctrl.fract = 1'b1;
        ctrl.signA = 1'b1; ctrl.signB = 1'b1;
      end
      OP_FMULSU: begin ctrl.opClass = CL_MUL; ctrl.fract = 1'b1; ctrl.signA = 1'b1; end
      OP_MOV:  ctrl.opClass = CL_MOV;
      OP_MOVW: begin ctrl.opClass = CL_MOV; ctrl.wordOut = 1'b1; end
      default: ctrl.writeRes = 1'b0;
    endcase
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = WIMM_W
) (
  input  aluCtrlT         ctrl,
  input  logic [DW-1:0]   rdA,
  input  logic [DW-1:0]   rdB,
  input  logic [DW-1:0]   immByte,
  input  logic            useImm,
  input  logic            wordMode,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [2*DW-1:0] resNext,
  output logic [FLAG_W-1:0] flagsNext
);
  localparam int WW = 2 * DW;
  localparam int MB = DW - 1;
  localparam int HB = DW / 2 - 1;
  localparam int NB = DW / 2;

  logic [WW-1:0] opA;
  logic [DW-1:0] aLo, opB;
  logic          cin, zc;
  logic [DW:0]   sum9, dif9;
  logic [WW-1:0] immW, wSum, wDif;
  logic signed [DW:0]     aX, bX;
  logic signed [WW+1:0]   prodFull;
  logic [WW-1:0] prod, mulRes;
  logic [DW-1:0] incR, decR, negR, logicR, shiftR;

  assign opA  = wordMode ? {rdB, rdA} : {{DW{1'b0}}, rdA};
  assign aLo  = opA[DW-1:0];
  assign opB  = useImm ? immByte : rdB;
  assign cin  = ctrl.useCarry & flagsIn[FL_C];
  assign zc   = ctrl.zChain ? flagsIn[FL_Z] : 1'b1;

  assign sum9 = {1'b0, aLo} + {1'b0, opB} + {{DW{1'b0}}, cin};
  assign dif9 = {1'b0, aLo} - {1'b0, opB} - {{DW{1'b0}}, cin};
  assign immW = {{(WW-IW){1'b0}}, immByte[IW-1:0]};
  assign wSum = opA + immW;
  assign wDif = opA - immW;
  assign incR = aLo + 1'b1;
  assign decR = aLo - 1'b1;
  assign negR = '0 - aLo;

  assign aX = {ctrl.signA & aLo[MB], aLo};
  assign bX = {ctrl.signB & opB[MB], opB};
  assign prodFull = aX * bX;
  assign prod     = prodFull[WW-1:0];
  assign mulRes   = ctrl.fract ? {prod[WW-2:0], 1'b0} : prod;

  always_comb begin
    unique case (ctrl.subSel)
      2'd0:    logicR = aLo & opB;
      2'd1:    logicR = aLo | opB;
      default: logicR = aLo ^ opB;
    endcase
    unique case (ctrl.subSel)
      2'd0:    shiftR = {1'b0, aLo[MB:1]};
      2'd1:    shiftR = {flagsIn[FL_C], aLo[MB:1]};
      default: shiftR = {aLo[MB], aLo[MB:1]};
    endcase
  end

  logic [DW-1:0] r8;
  logic updByte, updWord;

  always_comb begin
    r8        = aLo;
    resNext   = opA;
    flagsNext = flagsIn;
    updByte   = 1'b0;
    updWord   = 1'b0;
    unique case (ctrl.opClass)
      CL_ADD: begin
        r8 = sum9[DW-1:0];
        flagsNext[FL_C] = sum9[DW];
        flagsNext[FL_H] = (aLo[HB] & opB[HB]) | (opB[HB] & ~r8[HB]) | (~r8[HB] & aLo[HB]);
        flagsNext[FL_V] = (aLo[MB] & opB[MB] & ~r8[MB]) | (~aLo[MB] & ~opB[MB] & r8[MB]);
        updByte = 1'b1;
      end
      CL_SUB: begin
        r8 = dif9[DW-1:0];
        flagsNext[FL_C] = (~aLo[MB] & opB[MB]) | (opB[MB] & r8[MB]) | (r8[MB] & ~aLo[MB]);
        flagsNext[FL_H] = (~aLo[HB] & opB[HB]) | (opB[HB] & r8[HB]) | (r8[HB] & ~aLo[HB]);
        flagsNext[FL_V] = (aLo[MB] & ~opB[MB] & ~r8[MB]) | (~aLo[MB] & opB[MB] & r8[MB]);
        updByte = 1'b1;
      end
      CL_ADDW: begin
        resNext = wSum;
        flagsNext[FL_V] = ~opA[WW-1] & wSum[WW-1];
        flagsNext[FL_C] = opA[WW-1] & ~wSum[WW-1];
        updWord = 1'b1;
      end
      CL_SUBW: begin
        resNext = wDif;
        flagsNext[FL_V] = opA[WW-1] & ~wDif[WW-1];
        flagsNext[FL_C] = ~opA[WW-1] & wDif[WW-1];
        updWord = 1'b1;
      end
      CL_INC: begin
        r8 = incR;
        flagsNext[FL_V] = incR[MB] & ~(|incR[MB-1:0]);
        updByte = 1'b1;
      end
      CL_DEC: begin
        r8 = decR;
        flagsNext[FL_V] = ~decR[MB] & (&decR[MB-1:0]);
        updByte = 1'b1;
      end
      CL_LOGIC: begin
        r8 = logicR;
        flagsNext[FL_V] = 1'b0;
        updByte = 1'b1;
      end
      CL_COM: begin
        r8 = ~aLo;
        flagsNext[FL_C] = 1'b1;
        flagsNext[FL_V] = 1'b0;
        updByte = 1'b1;
      end
      CL_NEG: begin
        r8 = negR;
        flagsNext[FL_C] = |negR;
        flagsNext[FL_V] = negR[MB] & ~(|negR[MB-1:0]);
        flagsNext[FL_H] = negR[HB] | aLo[HB];
        updByte = 1'b1;
      end
      CL_SWAP: begin
        r8 = {aLo[NB-1:0], aLo[DW-1:NB]};
        resNext = {{DW{1'b0}}, r8};
      end
      CL_SHIFT: begin
        r8 = shiftR;
        flagsNext[FL_C] = aLo[0];
        flagsNext[FL_V] = shiftR[MB] ^ aLo[0];
        updByte = 1'b1;
      end
      CL_MUL: begin
        resNext = mulRes;
        flagsNext[FL_C] = prod[WW-1];
        flagsNext[FL_Z] = (mulRes == '0);
      end
      CL_MOV: begin
        if (!ctrl.wordOut) resNext = {{DW{1'b0}}, aLo};
      end
      default: resNext = '0;
    endcase
    if (updByte) begin
      resNext = {{DW{1'b0}}, r8};
      flagsNext[FL_N] = r8[MB];
      flagsNext[FL_Z] = (r8 == '0) & zc;
    end
    if (updWord) begin
      flagsNext[FL_N] = resNext[WW-1];
      flagsNext[FL_Z] = (resNext == '0);
    end
    if (updByte || updWord) flagsNext[FL_S] = flagsNext[FL_N] ^ flagsNext[FL_V];
  end
endmodule

// File: rtl/mcuAlu.sv
module mcuAlu
  import aluPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                stageEn,
  input  logic [DATA_W-1:0]   rdA,
  input  logic [DATA_W-1:0]   rdB,
  input  logic [DATA_W-1:0]   immByte,
  input  logic                useImm,
  input  logic                wordMode,
  input  logic [OP_W-1:0]     opCode,
  input  logic [FLAG_W-1:0]   flagsIn,
  output logic [2*DATA_W-1:0] result,
  output logic [FLAG_W-1:0]   flagsOut,
  output logic                resultWe
);
  aluCtrlT                ctrl;
  logic [2*DATA_W-1:0]    resNext;
  logic [FLAG_W-1:0]      flagsNext;

  aluControl u_ctrl (.opCode(opCode), .ctrl(ctrl));

  aluDatapath #(.DW(DATA_W), .IW(WIMM_W)) u_dp (
    .ctrl(ctrl), .rdA(rdA), .rdB(rdB), .immByte(immByte),
    .useImm(useImm), .wordMode(wordMode), .flagsIn(flagsIn),
    .resNext(resNext), .flagsNext(flagsNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      flagsOut <= '0;
      resultWe <= 1'b0;
    end else if (stageEn) begin
      result   <= resNext;
      flagsOut <= flagsNext;
      resultWe <= ctrl.writeRes;
    end
  end
endmodule

// File: rtl/aluChecker.sv
module aluChecker
  import aluPkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                stageEn,
  input logic [DATA_W-1:0]   rdA,
  input logic [DATA_W-1:0]   rdB,
  input logic [DATA_W-1:0]   immByte,
  input logic                useImm,
  input logic                wordMode,
  input logic [OP_W-1:0]     opCode,
  input logic [FLAG_W-1:0]   flagsIn,
  input logic [2*DATA_W-1:0] result,
  input logic [FLAG_W-1:0]   flagsOut,
  input logic                resultWe
);
  logic rstQ;
  always_ff @(posedge clk) rstQ <= rst;

  // R13: outputs are clear one edge after reset
  always @(negedge clk)
    if (rstQ) p_reset_clear_r13: assert (result == '0 && flagsOut == '0 && !resultWe);

  p_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !stageEn |=> ($stable(result) && $stable(flagsOut) && $stable(resultWe)));

  p_cmp_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
    (stageEn && (opCode == OP_CMP || opCode == OP_CMPC)) |=> !resultWe);

  p_zchain_r4: assert property (@(posedge clk) disable iff (rst)
    (stageEn && (opCode == OP_SBC || opCode == OP_CMPC) && !flagsIn[FL_Z]) |=> !flagsOut[FL_Z]);

  p_swap_flags_r10: assert property (@(posedge clk) disable iff (rst)
    (stageEn && opCode == OP_SWAP) |=> (flagsOut == $past(flagsIn)));

  p_mul_value_r11: assert property (@(posedge clk) disable iff (rst)
    (stageEn && opCode == OP_MULUU && !useImm) |=>
      (result == ($past({8'h00, rdA}) * $past({8'h00, rdB}))));

  p_fmul_lsb_r12: assert property (@(posedge clk) disable iff (rst)
    (stageEn && (opCode == OP_FMULUU || opCode == OP_FMULSS || opCode == OP_FMULSU))
      |=> !result[0]);

  p_undef_r14: assert property (@(posedge clk) disable iff (rst)
    (stageEn && opCode > OP_MOVW) |=> (result == '0 && !resultWe && flagsOut == $past(flagsIn)));
endmodule

bind mcuAlu aluChecker u_chk (.*);

// File: tb/test_mcuAlu.sv
`timescale 1ns/1ps
module test_mcuAlu;
  import aluPkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stageEn = 1'b0;
  logic [7:0] rdA = '0, rdB = '0, immByte = '0;
  logic useImm = 1'b0, wordMode = 1'b0;
  logic [4:0] opCode = '0;
  logic [5:0] flagsIn = '0;
  logic [15:0] result;
  logic [5:0] flagsOut;
  logic resultWe;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  mcuAlu i_mcuAlu (
    .clk(clk), .rst(rst), .stageEn(stageEn), .rdA(rdA), .rdB(rdB),
    .immByte(immByte), .useImm(useImm), .wordMode(wordMode),
    .opCode(opCode), .flagsIn(flagsIn), .result(result),
    .flagsOut(flagsOut), .resultWe(resultWe)
  );

  function automatic int sx8(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int sx16(input int v);
    return (v > 32767) ? v - 65536 : v;
  endfunction

  // returns {we, flags[5:0], result[15:0]}
  function automatic logic [22:0] model(input logic [7:0] a, b, im,
                                        input logic ui, wm,
                                        input logic [4:0] op,
                                        input logic [5:0] fin);
    int aL, aw, bv, c, u, s, r, i6, ua, ub;
    logic [5:0] f;
    logic we, setNZ, zOk;
    aL = int'(a);
    aw = wm ? int'({b, a}) : aL;
    bv = ui ? int'(im) : int'(b);
    i6 = int'(im[5:0]);
    c = 0; r = 0; f = fin; we = 1'b1; setNZ = 1'b0; zOk = 1'b1;
    case (op)
      5'd0, 5'd1: begin
        c = (op == 5'd1) ? int'(fin[0]) : 0;
        u = aL + bv + c; r = u & 255;
        f[0] = (u > 255);
        f[5] = ((aL & 15) + (bv & 15) + c) > 15;
        s = sx8(aL) + sx8(bv) + c;
        f[3] = (s > 127) || (s < -128);
        setNZ = 1'b1;
      end
      5'd3, 5'd4, 5'd13, 5'd14: begin
        c = (op == 5'd4 || op == 5'd14) ? int'(fin[0]) : 0;
        if (op == 5'd4 || op == 5'd14) zOk = fin[1];
        r = (aL - bv - c) & 255;
        f[0] = aL < bv + c;
        f[5] = (aL & 15) < ((bv & 15) + c);
        s = sx8(aL) - sx8(bv) - c;
        f[3] = (s > 127) || (s < -128);
        we = !(op == 5'd13 || op == 5'd14);
        setNZ = 1'b1;
      end
      5'd2, 5'd5: begin
        if (op == 5'd2) begin
          u = aw + i6; f[0] = u > 65535; s = sx16(aw) + i6; f[3] = s > 32767;
        end else begin
          u = aw - i6; f[0] = aw < i6; s = sx16(aw) - i6; f[3] = s < -32768;
        end
        r = u & 65535;
        f[2] = r[15]; f[1] = (r == 0); f[4] = f[2] ^ f[3];
      end
      5'd6: begin r = (aL + 1) & 255; f[3] = (aL == 127); setNZ = 1'b1; end
      5'd7: begin r = (aL - 1) & 255; f[3] = (aL == 128); setNZ = 1'b1; end
      5'd8, 5'd9, 5'd10: begin
        r = (op == 5'd8) ? (aL & bv) : (op == 5'd9) ? (aL | bv) : (aL ^ bv);
        f[3] = 1'b0; setNZ = 1'b1;
      end
      5'd11: begin r = 255 - aL; f[0] = 1'b1; f[3] = 1'b0; setNZ = 1'b1; end
      5'd12: begin
        r = (256 - aL) & 255; f[0] = (r != 0); f[3] = (r == 128);
        f[5] = (aL & 15) != 0; setNZ = 1'b1;
      end
      5'd15: r = ((aL & 15) << 4) | (aL >> 4);
      5'd16, 5'd17, 5'd18: begin
        r = aL >> 1;
        if (op == 5'd17 && fin[0]) r = r | 128;
        if (op == 5'd18) r = r | (aL & 128);
        f[0] = aL[0]; f[3] = r[7] ^ aL[0]; setNZ = 1'b1;
      end
      5'd19, 5'd20, 5'd21, 5'd22, 5'd23, 5'd24: begin
        ua = (op == 5'd19 || op == 5'd22) ? aL : sx8(aL);
        ub = (op == 5'd20 || op == 5'd23) ? sx8(bv) : bv;
        u = (ua * ub) & 65535;
        f[0] = u[15];
        r = (op >= 5'd22) ? ((u << 1) & 65535) : u;
        f[1] = (r == 0);
      end
      5'd25: r = aL;
      5'd26: r = aw;
      default: begin r = 0; we = 1'b0; end
    endcase
    if (setNZ) begin
      f[2] = r[7]; f[1] = (r == 0) && zOk; f[4] = f[2] ^ f[3];
    end
    return {we, f, r[15:0]};
  endfunction

  function automatic string reqOf(input logic [4:0] op);
    case (op)
      5'd0, 5'd1, 5'd3:           return "R3";
      5'd4, 5'd14:                return "R4";
      5'd13:                      return "R5";
      5'd2, 5'd5:                 return "R6";
      5'd6, 5'd7, 5'd11, 5'd12:   return "R7";
      5'd8, 5'd9, 5'd10:          return "R8";
      5'd16, 5'd17, 5'd18:        return "R9";
      5'd15, 5'd25, 5'd26:        return "R10";
      5'd19, 5'd20, 5'd21:        return "R11";
      5'd22, 5'd23, 5'd24:        return "R12";
      default:                    return "R14";
    endcase
  endfunction

  task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual we=%0b flags=%02h res=%04h expected we=%0b flags=%02h res=%04h",
               req, act[22], act[21:16], act[15:0], exp[22], exp[21:16], exp[15:0]);
    end
  endtask

  task automatic runOp(input string req, input logic [4:0] op, input logic [7:0] a, b, im,
                       input logic ui, wm, input logic [5:0] fin);
    logic [22:0] exp;
    @(negedge clk);
    stageEn = 1'b1; opCode = op; rdA = a; rdB = b; immByte = im;
    useImm = ui; wordMode = wm; flagsIn = fin;
    exp = model(a, b, im, ui, wm, op, fin);
    @(posedge clk);
    @(negedge clk);
    check((req == "") ? reqOf(op) : req, {resultWe, flagsOut, result}, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [22:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13", {resultWe, flagsOut, result}, 23'd0);
    rst = 1'b0;

    // directed corners
    runOp("R3",  5'd0,  8'h7F, 8'h01, 8'h00, 1'b0, 1'b0, 6'h00);
    runOp("R3",  5'd0,  8'hFF, 8'h01, 8'h00, 1'b0, 1'b0, 6'h00);
    runOp("R3",  5'd1,  8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 6'h01);
    runOp("R4",  5'd4,  8'h10, 8'h0F, 8'h00, 1'b0, 1'b0, 6'h01);
    runOp("R4",  5'd4,  8'h10, 8'h0F, 8'h00, 1'b0, 1'b0, 6'h03);
    runOp("R5",  5'd14, 8'h22, 8'h21, 8'h00, 1'b0, 1'b0, 6'h03);
    runOp("R5",  5'd13, 8'h05, 8'h00, 8'h05, 1'b1, 1'b0, 6'h00);
    runOp("R2",  5'd3,  8'h40, 8'h01, 8'h40, 1'b1, 1'b0, 6'h00);
    runOp("R2",  5'd3,  8'h40, 8'h01, 8'h40, 1'b0, 1'b0, 6'h00);
    runOp("R6",  5'd2,  8'hFF, 8'h7F, 8'h01, 1'b1, 1'b1, 6'h00);
    runOp("R6",  5'd2,  8'hF0, 8'hFF, 8'hFF, 1'b1, 1'b1, 6'h00);
    runOp("R6",  5'd5,  8'h00, 8'h00, 8'h01, 1'b1, 1'b1, 6'h00);
    runOp("R6",  5'd5,  8'h00, 8'h80, 8'h01, 1'b1, 1'b1, 6'h20);
    runOp("R7",  5'd6,  8'h7F, 8'h00, 8'h00, 1'b0, 1'b0, 6'h21);
    runOp("R7",  5'd7,  8'h80, 8'h00, 8'h00, 1'b0, 1'b0, 6'h00);
    runOp("R7",  5'd12, 8'h80, 8'h00, 8'h00, 1'b0, 1'b0, 6'h00);
    runOp("R7",  5'd12, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 6'h3F);
    runOp("R9",  5'd17, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 6'h01);
    runOp("R9",  5'd18, 8'h81, 8'h00, 8'h00, 1'b0, 1'b0, 6'h00);
    runOp("R10", 5'd15, 8'hA5, 8'h00, 8'h00, 1'b0, 1'b0, 6'h2A);
    runOp("R1",  5'd26, 8'h34, 8'h12, 8'h00, 1'b0, 1'b1, 6'h15);
    runOp("R1",  5'd25, 8'h34, 8'h12, 8'h00, 1'b0, 1'b1, 6'h15);
    runOp("R11", 5'd20, 8'h80, 8'h80, 8'h00, 1'b0, 1'b0, 6'h00);
    runOp("R11", 5'd21, 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b0, 6'h00);
    runOp("R12", 5'd23, 8'h80, 8'h80, 8'h00, 1'b0, 1'b0, 6'h00);
    runOp("R12", 5'd22, 8'h80, 8'h02, 8'h00, 1'b0, 1'b0, 6'h00);
    runOp("R14", 5'd30, 8'h12, 8'h34, 8'h56, 1'b0, 1'b0, 6'h2D);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] rv;
      rv = $urandom;
      runOp("", 5'(rv[4:0] % 5'd28), 8'($urandom), 8'($urandom), 8'($urandom),
            rv[8], rv[9], rv[15:10]);
    end

    // hold while disabled
    runOp("R13", 5'd0, 8'h11, 8'h22, 8'h00, 1'b0, 1'b0, 6'h00);
    held = {resultWe, flagsOut, result};
    @(negedge clk);
    stageEn = 1'b0; opCode = 5'd11; rdA = 8'h5A; flagsIn = 6'h3F;
    repeat (3) @(negedge clk);
    check("R13", {resultWe, flagsOut, result}, held);

    // synchronous reset mid-run
    @(negedge clk);
    stageEn = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R13", {resultWe, flagsOut, result}, 23'd0);
    rst = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule